// File: doc/BRIEF.md
# Predicate File with Qualified Commit

This block keeps a bank of one-bit predicate registers and uses them to decide, for every issued instruction, whether that instruction's result is committed and whether its exception request leaves the block. Each cycle the issue side presents a qualifying-predicate index, a result-valid flag, a destination register index with its data, and an exception-request flag. The block looks up the selected predicate and registers gated write and exception signals, so they appear one cycle later.

Predicate register 0 is fixed at true and cannot be changed. Other predicates are written through a single write port that takes an index and a value. A second, general read port returns any predicate combinationally, for example to resolve a branch. A write becomes visible on the cycle after it is presented. A read of the same register in the write cycle returns the old value.

Top module: `pred_commit_unit`

## Requirements
- R1: After reset, predicates 1 to 63 read 0 and predicate 0 reads 1. Predicates are addressed by a 6-bit index. Both registered outputs `wr_en_o` and `exc_o` are 0 after reset.
- R2: Predicate 0 reads 1 on both read paths at all times.
- R3: A predicate write with index 0 changes nothing.
- R4: A write to a nonzero index with `pw_en_i`=1 takes effect on the following cycle. A read of that index in the write cycle, on either path, returns the previous value.
- R5: One cycle after an issue cycle, `wr_en_o` equals `iss_valid_i` AND the selected qualifying predicate.
- R6: Whenever `wr_en_o` is 1, `wr_idx_o` and `wr_data_o` equal the destination index and data presented with that instruction.
- R7: One cycle after an issue cycle, `exc_o` equals `exc_req_i` AND `iss_valid_i` AND the selected qualifying predicate.
- R8: When the selected qualifying predicate is 0, neither `wr_en_o` nor `exc_o` asserts on the next cycle, whatever `iss_valid_i` and `exc_req_i` are.
- R9: `br_pred_o` returns the current value of the predicate selected by `br_idx_i` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pw_en_i | input | 1 | Predicate write enable |
| pw_idx_i | input | 6 | Predicate write index |
| pw_val_i | input | 1 | Predicate write value |
| qp_idx_i | input | 6 | Qualifying-predicate index of the issued instruction |
| iss_valid_i | input | 1 | Issued instruction has a result |
| dst_idx_i | input | 7 | Destination register index |
| dst_data_i | input | 64 | Destination data |
| exc_req_i | input | 1 | Exception request of the issued instruction |
| br_idx_i | input | 6 | General predicate read index |
| br_pred_o | output | 1 | General predicate read value |
| wr_en_o | output | 1 | Gated register-write enable, registered |
| wr_idx_o | output | 7 | Destination index of the committed write |
| wr_data_o | output | 64 | Data of the committed write |
| exc_o | output | 1 | Gated exception, registered |

## Verification
The assertions assume that every index input is within the 64-entry range, which holds because each index is exactly six bits wide. They also assume that the issue inputs of each cycle stand alone, so an output depends only on the inputs of the previous cycle. The stimulus drives every input at the falling edge and holds it through the rising edge. It sweeps every qualifying index against all combinations of valid and exception. It also mixes random writes, including writes to index 0 and writes that collide with a same-cycle read, and all indices stay inside the six-bit range.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef struct packed {
    logic wr;
    logic exc;
  } commit_ctl_t;

  function automatic commit_ctl_t gate_commit(input logic valid, input logic qp, input logic exc);
    commit_ctl_t c;
    c.wr  = valid & qp;
    c.exc = exc & valid & qp;
    return c;
  endfunction

endpackage

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int NUM_PRED = 64,
  parameter int N_RD     = 2,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           widx_i,
  input  logic                       wval_i,
  input  logic [N_RD-1:0][IDX_W-1:0] rd_idx_i,
  output logic [N_RD-1:0]            rd_val_o
);

  logic [NUM_PRED-1:1] store_q;
  logic [NUM_PRED-1:0] pr_all;

  // entry 0 has no storage; writes to it match no slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= '0;
    end else if (we_i) begin
      for (int i = 1; i < NUM_PRED; i++) begin
        if (widx_i == IDX_W'(i)) store_q[i] <= wval_i;
      end
    end
  end

  assign pr_all = {store_q, 1'b1};

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_val_o[r] = pr_all[rd_idx_i[r]];
  end

endmodule

// File: rtl/commit_gate.sv
module commit_gate
  import pred_pkg::*;
#(
  parameter int DST_W  = 7,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              qp_i,
  input  logic              exc_i,
  input  logic [DST_W-1:0]  dst_idx_i,
  input  logic [DATA_W-1:0] dst_data_i,
  output logic              wr_en_o,
  output logic              exc_o,
  output logic [DST_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);

  commit_ctl_t ctl_d, ctl_q;

  assign ctl_d = gate_commit(valid_i, qp_i, exc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= '0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (ctl_d.wr) begin
        wr_idx_o  <= dst_idx_i;
        wr_data_o <= dst_data_i;
      end
    end
  end

  assign wr_en_o = ctl_q.wr;
  assign exc_o   = ctl_q.exc;

endmodule

// File: rtl/pred_commit_unit.sv
module pred_commit_unit #(
  parameter int NUM_PRED = 64,
  parameter int DST_W    = 7,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pw_en_i,
  input  logic [IDX_W-1:0]  pw_idx_i,
  input  logic              pw_val_i,
  input  logic [IDX_W-1:0]  qp_idx_i,
  input  logic              iss_valid_i,
  input  logic [DST_W-1:0]  dst_idx_i,
  input  logic [DATA_W-1:0] dst_data_i,
  input  logic              exc_req_i,
  input  logic [IDX_W-1:0]  br_idx_i,
  output logic              br_pred_o,
  output logic              wr_en_o,
  output logic [DST_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              exc_o
);

  localparam int RD_QP = 0;
  localparam int RD_BR = 1;

  logic [1:0][IDX_W-1:0] rd_idx;
  logic [1:0]            rd_val;
  logic                  qp_val;

  assign rd_idx[RD_QP] = qp_idx_i;
  assign rd_idx[RD_BR] = br_idx_i;
  assign qp_val        = rd_val[RD_QP];
  assign br_pred_o     = rd_val[RD_BR];

  pred_bank #(.NUM_PRED(NUM_PRED), .N_RD(2)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pw_en_i),
    .widx_i   (pw_idx_i),
    .wval_i   (pw_val_i),
    .rd_idx_i (rd_idx),
    .rd_val_o (rd_val)
  );

  commit_gate #(.DST_W(DST_W), .DATA_W(DATA_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (iss_valid_i),
    .qp_i       (qp_val),
    .exc_i      (exc_req_i),
    .dst_idx_i  (dst_idx_i),
    .dst_data_i (dst_data_i),
    .wr_en_o    (wr_en_o),
    .exc_o      (exc_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o)
  );

endmodule

// File: rtl/pred_commit_chk.sv
module pred_commit_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] qp_idx_i,
  input logic             iss_valid_i,
  input logic             exc_req_i,
  input logic [IDX_W-1:0] br_idx_i,
  input logic             br_pred_o,
  input logic             qp_val,
  input logic             wr_en_o,
  input logic             exc_o
);

  AST_P0_BR_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_idx_i == '0 |-> br_pred_o);  // R2
  AST_P0_QP_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qp_idx_i == '0 |-> qp_val);  // R2
  AST_COMMIT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_i && qp_val |=> wr_en_o);  // R5
  AST_NO_SQUASHED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iss_valid_i && qp_val) |=> !wr_en_o);  // R5
  AST_NO_SQUASHED_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qp_val |=> !exc_o);  // R8
  AST_EXC_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_i |=> !exc_o);  // R7
  AST_EXC_WITH_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> wr_en_o);  // R7

endmodule

bind pred_commit_unit pred_commit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .qp_idx_i    (qp_idx_i),
  .iss_valid_i (iss_valid_i),
  .exc_req_i   (exc_req_i),
  .br_idx_i    (br_idx_i),
  .br_pred_o   (br_pred_o),
  .qp_val      (qp_val),
  .wr_en_o     (wr_en_o),
  .exc_o       (exc_o)
);

// File: tb/sim_pred_commit_unit.sv
`timescale 1ns/1ps
module sim_pred_commit_unit;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pw_en_i = 1'b0;
  logic [5:0]  pw_idx_i = '0;
  logic        pw_val_i = 1'b0;
  logic [5:0]  qp_idx_i = '0;
  logic        iss_valid_i = 1'b0;
  logic [6:0]  dst_idx_i = '0;
  logic [63:0] dst_data_i = '0;
  logic        exc_req_i = 1'b0;
  logic [5:0]  br_idx_i = '0;
  logic        br_pred_o, wr_en_o, exc_o;
  logic [6:0]  wr_idx_o;
  logic [63:0] wr_data_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic model [64];

  always #10 clk = ~clk;

  pred_commit_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pw_en_i(pw_en_i), .pw_idx_i(pw_idx_i),
    .pw_val_i(pw_val_i), .qp_idx_i(qp_idx_i), .iss_valid_i(iss_valid_i),
    .dst_idx_i(dst_idx_i), .dst_data_i(dst_data_i), .exc_req_i(exc_req_i),
    .br_idx_i(br_idx_i), .br_pred_o(br_pred_o), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .exc_o(exc_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic step(input string br_tag, input logic pe, input logic [5:0] pi, input logic pv,
                      input logic v, input logic [5:0] q, input logic [6:0] d,
                      input logic [63:0] dat, input logic e, input logic [5:0] b);
    logic exp_wr, exp_exc;
    pw_en_i = pe; pw_idx_i = pi; pw_val_i = pv;
    iss_valid_i = v; qp_idx_i = q; dst_idx_i = d; dst_data_i = dat;
    exc_req_i = e; br_idx_i = b;
    #1;
    chk(br_tag, br_pred_o, model[b]);
    exp_wr  = v & model[q];
    exp_exc = e & v & model[q];
    @(posedge clk); #1;
    chk(model[q] ? "R5" : "R8 wr", wr_en_o, exp_wr);
    chk(model[q] ? "R7" : "R8 exc", exc_o, exp_exc);
    if (exp_wr) begin
      chk("R6 idx", wr_idx_o, d);
      chk("R6 data", wr_data_o, dat);
    end
    if (pe && pi != 0) model[pi] = pv;
    @(negedge clk);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    #35;
    chk("R1 wr_en reset", wr_en_o, 0);
    chk("R1 exc reset", exc_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset contents through the general read port
    for (int i = 0; i < 64; i++) step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 6'(i));
    // R3: try to clear predicate 0, then read it on both paths
    step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 0, 7'd5, 64'hA5, 1, 0);
    // R4: write every index, reading it in the same cycle on both paths
    for (int i = 1; i < 64; i++)
      step("R4 same-cycle", 1, 6'(i), (i % 3) != 0, 1, 6'(i), 7'(i), 64'(i) * 64'h1111, 1, 6'(i));
    for (int i = 0; i < 64; i++) step("R4 visible", 0, 0, 0, 0, 0, 0, 0, 0, 6'(i));
    // R5/R7/R8: sweep every qualifying index over valid and exception
    for (int i = 0; i < 64; i++)
      for (int m = 0; m < 4; m++)
        step("R9", 0, 0, 0, m[0], 6'(i), 7'(i + m), {32'hC0DE0000, 32'(i * 4 + m)}, m[1], 6'(63 - i));
    // random mix, including writes to index 0 and read/write collisions
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] wi;
      wi = 6'($urandom_range(0, 63));
      step("R9 random", $urandom_range(0, 1), wi, $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 3) == 0) ? wi : 6'($urandom_range(0, 63)),
           7'($urandom), {$urandom, $urandom}, $urandom_range(0, 1),
           ($urandom_range(0, 7) == 0) ? 6'd0 : 6'($urandom_range(0, 63)));
    end
    step("R2 final", 0, 0, 0, 1, 0, 7'd1, 64'd1, 0, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule